// File: doc/BRIEF.md
# Interrupt Status Collector for an External Memory Controller

This block gathers single-cycle event pulses from an external memory controller and turns them into one interrupt line. There are two kinds of events: a timeout of an asynchronous access whose wait was stretched too long, and a rising edge seen on each of the controller's wait inputs. Each event sets a sticky status bit, and a per-bit enable decides whether that bit may raise the interrupt.

Software sees the state through four word-addressed views of the same storage. Two status views show the sticky bits without and with the enable applied. Two enable views set or clear enable bits when 1 is written. Writing 1 to either status view clears the bit in both, and both enable views read back the same enable vector. Access is a single-cycle register port: read data is combinational from the address, and a write takes effect at the clock edge where the write enable is high.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every status bit and every enable bit is 0, all four views read 0 and `irq_o` is 0.
- R2: Bit layout of every view: bit 0 is the access-timeout event and bit 1+k is the rising-edge event of wait input k. A pulse on an event input sets its status bit at that clock edge, whatever the enable.
- R3: Writing to view address 0 (unmasked status) clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R4: Writing to view address 1 (masked status) clears each status bit whose data bit is 1, so the bit reads 0 in both status views afterwards. Data bits that are 0 have no effect.
- R5: Writing to view address 2 (enable-set) sets each enable bit whose data bit is 1. The bit then reads 1 at both address 2 and address 3. Data bits that are 0 have no effect.
- R6: Writing to view address 3 (enable-clear) clears each enable bit whose data bit is 1. The bit then reads 0 at both enable addresses. Data bits that are 0 have no effect.
- R7: Address 1 reads the bitwise AND of the status bits and the enable bits.
- R8: `irq_o` is a register that holds the OR of all masked status bits as they stood one clock earlier.
- R9: If an event pulse and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R10: Bit positions above the event bits read 0 in every view, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_timeout_i | input | 1 | Single-cycle pulse: an asynchronous access timed out |
| evt_wait_rise_i | input | NUM_WAIT | Single-cycle pulses: rising edge on each wait input |
| reg_addr_i | input | 2 | View select: 0 status, 1 masked status, 2 enable-set, 3 enable-clear |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected view |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An event pulse and a write-1-to-clear can land on the same status bit in the same cycle. The bench provokes this by driving every event pattern together with a clear of all bits, through each of the two status views, and judges the outcome by reading the status view afterwards: every pulsed bit must still be set and every other bit must be cleared. The bench also sweeps all enable and event patterns of a small configuration and computes the expected views and interrupt arithmetically.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        VIEW_RAW    = 2'd0,
        VIEW_MASKED = 2'd1,
        VIEW_EN_SET = 2'd2,
        VIEW_EN_CLR = 2'd3
    } view_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_stat_pkg::*;
#(
    parameter int N_EVT = 3
) (
    input  logic [1:0]       addr_i,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [N_EVT-1:0] raw_i,
    input  logic [N_EVT-1:0] en_i,
    output logic [N_EVT-1:0] clr_stat_o,
    output logic [N_EVT-1:0] set_en_o,
    output logic [N_EVT-1:0] clr_en_o,
    output logic [REG_W-1:0] rdata_o
);

    localparam int PAD_W = REG_W - N_EVT;

    view_e              view;
    logic [N_EVT-1:0]   wbits;
    logic [N_EVT-1:0]   sel_bits;

    assign view  = view_e'(addr_i);
    // Only the event positions of the write data are looked at; the rest is ignored.
    assign wbits = wdata_i[N_EVT-1:0];

    always_comb begin
        clr_stat_o = '0;
        set_en_o   = '0;
        clr_en_o   = '0;
        sel_bits   = '0;
        unique case (view)
            VIEW_RAW: begin
                sel_bits = raw_i;
                if (we_i) clr_stat_o = wbits;
            end
            VIEW_MASKED: begin
                sel_bits = raw_i & en_i;
                if (we_i) clr_stat_o = wbits;
            end
            VIEW_EN_SET: begin
                sel_bits = en_i;
                if (we_i) set_en_o = wbits;
            end
            VIEW_EN_CLR: begin
                sel_bits = en_i;
                if (we_i) clr_en_o = wbits;
            end
        endcase
    end

    assign rdata_o = {{PAD_W{1'b0}}, sel_bits};

endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank #(
    parameter int N_EVT = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EVT-1:0] evt_i,
    input  logic [N_EVT-1:0] clr_stat_i,
    input  logic [N_EVT-1:0] set_en_i,
    input  logic [N_EVT-1:0] clr_en_i,
    output logic [N_EVT-1:0] raw_o,
    output logic [N_EVT-1:0] en_o
);

    for (genvar i = 0; i < N_EVT; i++) begin : g_bit
        logic raw_q;
        logic en_q;

        // Status: an arriving event outranks a clear in the same cycle.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                raw_q <= 1'b0;
            end else if (evt_i[i]) begin
                raw_q <= 1'b1;
            end else if (clr_stat_i[i]) begin
                raw_q <= 1'b0;
            end
        end

        // Enable: set and clear come from different addresses, never together.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                en_q <= 1'b0;
            end else if (set_en_i[i]) begin
                en_q <= 1'b1;
            end else if (clr_en_i[i]) begin
                en_q <= 1'b0;
            end
        end

        assign raw_o[i] = raw_q;
        assign en_o[i]  = en_q;
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_stat_pkg::*;
#(
    parameter int NUM_WAIT = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                evt_timeout_i,
    input  logic [NUM_WAIT-1:0] evt_wait_rise_i,
    input  logic [1:0]          reg_addr_i,
    input  logic                reg_we_i,
    input  logic [REG_W-1:0]    reg_wdata_i,
    output logic [REG_W-1:0]    reg_rdata_o,
    output logic                irq_o
);

    localparam int N_EVT = NUM_WAIT + 1;

    logic [N_EVT-1:0] evt_vec;
    logic [N_EVT-1:0] raw_state;
    logic [N_EVT-1:0] en_state;
    logic [N_EVT-1:0] clr_stat;
    logic [N_EVT-1:0] set_en;
    logic [N_EVT-1:0] clr_en;
    logic             irq_q;

    // Bit 0 timeout, bits 1.. wait-rise per wait input.
    assign evt_vec = {evt_wait_rise_i, evt_timeout_i};

    irq_reg_decode #(.N_EVT(N_EVT)) u_decode (
        .addr_i     (reg_addr_i),
        .we_i       (reg_we_i),
        .wdata_i    (reg_wdata_i),
        .raw_i      (raw_state),
        .en_i       (en_state),
        .clr_stat_o (clr_stat),
        .set_en_o   (set_en),
        .clr_en_o   (clr_en),
        .rdata_o    (reg_rdata_o)
    );

    irq_event_bank #(.N_EVT(N_EVT)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt_vec),
        .clr_stat_i (clr_stat),
        .set_en_i   (set_en),
        .clr_en_i   (clr_en),
        .raw_o      (raw_state),
        .en_o       (en_state)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(raw_state & en_state);
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker #(
    parameter int N_EVT = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_EVT-1:0] evt_i,
    input logic [1:0]       addr_i,
    input logic             we_i,
    input logic [31:0]      wdata_i,
    input logic [31:0]      rdata_i,
    input logic [N_EVT-1:0] raw_i,
    input logic [N_EVT-1:0] en_i,
    input logic             irq_i
);

    a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((raw_i & $past(evt_i)) == $past(evt_i)));

    a_r3_raw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == 2'd0) |=> ((raw_i & $past(wdata_i[N_EVT-1:0] & ~evt_i)) == '0));

    a_r4_masked_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == 2'd1) |=> ((raw_i & $past(wdata_i[N_EVT-1:0] & ~evt_i)) == '0));

    a_r5_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == 2'd2) |=> ((en_i & $past(wdata_i[N_EVT-1:0])) == $past(wdata_i[N_EVT-1:0])));

    a_r6_enable_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == 2'd3) |=> ((en_i & $past(wdata_i[N_EVT-1:0])) == '0));

    a_r7_masked_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == 2'd1) |-> (rdata_i[N_EVT-1:0] == (raw_i & en_i)));

    a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i) |-> $past(|raw_i));

    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i[1] == 1'b0 && |(evt_i & wdata_i[N_EVT-1:0]))
        |=> ((raw_i & $past(evt_i)) == $past(evt_i)));

    a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_i[31:N_EVT] == '0);

endmodule

bind irq_status_unit irq_status_checker #(.N_EVT(NUM_WAIT + 1)) u_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_vec),
    .addr_i  (reg_addr_i),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_i (reg_rdata_o),
    .raw_i   (raw_state),
    .en_i    (en_state),
    .irq_i   (irq_o)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 2;
    localparam int NE         = NW + 1;
    localparam int ALL        = (1 << NE) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evt_to = 1'b0;
    logic [NW-1:0] evt_wr = '0;
    logic [1:0]    addr = 2'd0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_unit #(.NUM_WAIT(NW)) dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .evt_timeout_i   (evt_to),
        .evt_wait_rise_i (evt_wr),
        .reg_addr_i      (addr),
        .reg_we_i        (we),
        .reg_wdata_i     (wdata),
        .reg_rdata_o     (rdata),
        .irq_o           (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a write at a falling edge; it lands at the following rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [NE-1:0] ev);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        evt_to = ev[0]; evt_wr = ev[NE-1:1];
        @(negedge clk);
        we = 1'b0; wdata = '0; evt_to = 1'b0; evt_wr = '0;
    endtask

    task automatic pulse(input logic [NE-1:0] ev);
        @(negedge clk);
        evt_to = ev[0]; evt_wr = ev[NE-1:1];
        @(negedge clk);
        evt_to = 1'b0; evt_wr = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 view after reset", v, 32'h0);
        end
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        // Sweep every enable pattern against every event pattern.
        for (int e = 0; e <= ALL; e++) begin
            for (int p = 0; p <= ALL; p++) begin
                wr(2'd3, 32'hFFFF_FFFF, '0);
                wr(2'd2, e, '0);
                wr(2'd0, ALL, '0);
                @(negedge clk);
                pulse(p[NE-1:0]);
                rd(2'd0, v); check("R2 raw after events", v, p);
                rd(2'd1, v); check("R7 masked view", v, p & e);
                rd(2'd2, v); check("R5 enable-set view", v, e);
                rd(2'd3, v); check("R6 enable-clear view", v, e);
                @(negedge clk);
                check("R8 irq", {31'h0, irq}, {31'h0, |(p & e)});
                // Clear a subset through one of the status views.
                for (int c = 0; c <= ALL; c += 3) begin
                    wr((c & 1) ? 2'd1 : 2'd0, c, '0);
                    rd(2'd0, v);
                    check((c & 1) ? "R4 masked clear" : "R3 raw clear", v, p & ~c);
                    wr(2'd0, '0, '0);
                    rd(2'd1, v);
                    check("R3 write of zero", v, p & ~c & e);
                    pulse(p[NE-1:0]);
                end
            end
        end

        // R9: event and clear of all bits in the same cycle, via both status views.
        for (int p = 0; p <= ALL; p++) begin
            for (int s = 0; s < 2; s++) begin
                wr(2'd0, ALL, '0);
                wr(s[1:0], ALL, p[NE-1:0]);
                rd(2'd0, v);
                check("R9 set wins over clear", v, p);
            end
        end

        // R5/R6 zero bits no effect; R10 reserved bits.
        wr(2'd3, ALL, '0);
        wr(2'd2, 32'h5, '0);
        wr(2'd2, 32'h0, '0);
        rd(2'd3, v); check("R5 zero write to enable-set", v, 32'h5);
        wr(2'd3, 32'h1, '0);
        rd(2'd2, v); check("R6 partial enable clear", v, 32'h4);
        wr(2'd2, ~32'(ALL), '0);
        rd(2'd2, v); check("R10 reserved write to enable", v, 32'h4);
        wr(2'd0, ALL, '0);
        pulse(ALL);
        wr(2'd0, ~32'(ALL), '0);
        rd(2'd0, v); check("R10 reserved write to status", v, ALL);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R10 reserved bits read 0", v & ~32'(ALL), 32'h0);
        end
        // R2: timeout bit 0 and wait-rise bit 1+k individually.
        for (int k = 0; k < NE; k++) begin
            wr(2'd0, ALL, '0);
            pulse(NE'(1 << k));
            rd(2'd0, v); check("R2 single event position", v, 32'(1 << k));
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule